// File: doc/BRIEF.md
# Per-Line Request Coalescing Table

This block tracks every memory request that a processor port has outstanding towards a cache controller. Requests are grouped by cache-line address. Each occupied line slot holds a small ordered queue of the requests waiting on that line. Only a request that finds its line with nothing pending is forwarded downstream. A later request to a busy line is accepted and parked behind the earlier ones, so the requester never has to replay it. When the controller answers a line, the parked requests retire in arrival order, one per cycle. A write answer retires the whole queue. A read answer retires only loads and instruction fetches, and stops at the first store-type entry; that entry is sent downstream again using its forwarded type.

A line can be locked by a locked read-modify-write sequence. While a line is locked, only the matching locked write may enter; every other request to that line is refused with a retry indication and leaves no trace. A free-running cycle counter stamps each entry. A sticky error flag rises once any pending entry has waited at least a programmable number of cycles.

The request, issue, response and completion interfaces are valid/ready, and each transfer happens on a clock edge where both are high. The issue and completion outputs are registered, and they hold their content while ready is low. A request is held off (req_ready low) in four cases: its line queue is full, it needs a new slot and none is free, it must be forwarded but the issue register is still occupied, or its line is currently being drained. rsp_ready is low while a previous response is still being drained.

Top module: `line_coalesce_table`

## Requirements
- R1: A request (kind codes: 0 load, 1 instruction fetch, 2 store, 3 locked read-modify-write read, 4 locked read-modify-write write) to a line with no pending entries is accepted with req_alias=0 and req_retry=0. On the next cycle it appears on the issue port with its line and its forwarded kind.
- R2: A request to a line that already has pending entries is accepted with req_alias=1 and is not placed on the issue port.
- R3: req_ready is 0 in each of these cases: the line queue already holds DEPTH entries; the line is new and all SLOTS slots are occupied; the request needs issuing while iss_valid=1 and iss_ready=0.
- R4: A write response (rsp_write=1) completes every entry of its line in arrival order, one per cycle, each with its tag on cmp_tag.
- R5: A read response (rsp_write=0) completes load and fetch entries from the head of the queue until it reaches the first entry of kind 2, 3 or 4. That entry is reissued with its forwarded kind and stays pending.
- R6: Completing a kind-3 entry locks its line. A request of any kind other than 4 to a locked line is refused (req_retry=1): it is not stored, not counted and not issued. A kind-4 request to a locked line is accepted, and completing it unlocks the line.
- R7: cmp_ok is 1 for every completion except a kind-4 entry whose line was not locked, which reports cmp_ok=0.
- R8: out_count equals the number of pending entries. It rises by one per accepted request and falls by one per completion.
- R9: dl_err becomes 1 once a pending entry has waited at least dl_limit cycles, and it stays 1 until reset.
- R10: After reset, out_count=0, iss_valid=0, cmp_valid=0, dl_err=0 and req_ready=1.
- R11: While iss_ready=0 (or cmp_ready=0), iss_valid (or cmp_valid) and its content stay unchanged.
- R12: A slot is released when its queue empties and its line is unlocked, so a new line can be accepted afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be taken this cycle |
| req_line | input | LINE_W | Cache-line address of the request |
| req_kind | input | 3 | Primary kind of the request |
| req_fwd_kind | input | 3 | Kind to use when the request is sent downstream |
| req_tag | input | TAG_W | Requester tag, returned on completion |
| req_alias | output | 1 | Request is accepted but held behind earlier entries |
| req_retry | output | 1 | Request is refused because its line is locked |
| iss_valid | output | 1 | Downstream request valid |
| iss_ready | input | 1 | Downstream accepts the request |
| iss_line | output | LINE_W | Downstream line address |
| iss_kind | output | 3 | Downstream request kind |
| rsp_valid | input | 1 | Controller response valid |
| rsp_ready | output | 1 | Response can be taken |
| rsp_line | input | LINE_W | Line that the response refers to |
| rsp_write | input | 1 | 1 for a write response, 0 for a read response |
| cmp_valid | output | 1 | Completion valid |
| cmp_ready | input | 1 | Requester takes the completion |
| cmp_tag | output | TAG_W | Tag of the completed request |
| cmp_ok | output | 1 | Completion succeeded |
| out_count | output | clog2(SLOTS*DEPTH+1) | Number of pending entries |
| dl_limit | input | AGE_W | Age threshold for the stall error |
| dl_err | output | 1 | Sticky stall error |

## Verification
The hardest state to reach is a read response arriving for a line whose queue mixes loads with a store behind them. Reaching it needs several aliased requests to pile up on one line before any response is sent, and the drain must then stop part-way and reissue. The stimulus table builds such a queue (load, load, store, load), sends a read response and then a write response, and checks the exact retirement order and the reissued kind. A second hard case is a lock that outlives its empty queue. That case is reached by completing a locked read and then trying a plain load and a locked write on the same line.

// File: rtl/coal_pkg.sv
package coal_pkg;
  localparam logic [2:0] K_LOAD  = 3'd0;
  localparam logic [2:0] K_FETCH = 3'd1;
  localparam logic [2:0] K_STORE = 3'd2;
  localparam logic [2:0] K_LKRD  = 3'd3;
  localparam logic [2:0] K_LKWR  = 3'd4;

  function automatic logic k_is_read(input logic [2:0] k);
    return (k == K_LOAD) || (k == K_FETCH);
  endfunction
endpackage

// File: rtl/coal_lookup.sv
module coal_lookup #(
  parameter int SLOTS  = 8,
  parameter int LINE_W = 26,
  parameter int SLOT_W = 3
) (
  input  logic [SLOTS-1:0]  vld,
  input  logic [LINE_W-1:0] lines [SLOTS],
  input  logic [LINE_W-1:0] key,
  output logic              hit,
  output logic [SLOT_W-1:0] hit_idx,
  output logic              has_free,
  output logic [SLOT_W-1:0] free_idx
);
  always_comb begin
    hit      = 1'b0;
    hit_idx  = '0;
    has_free = 1'b0;
    free_idx = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (vld[i] && (lines[i] == key)) begin
        hit     = 1'b1;
        hit_idx = SLOT_W'(i);
      end
    end
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (!vld[i]) begin
        has_free = 1'b1;
        free_idx = SLOT_W'(i);
      end
    end
  end
endmodule

// File: rtl/coal_age_watch.sv
module coal_age_watch #(
  parameter int N     = 32,
  parameter int AGE_W = 16
) (
  input  logic [N-1:0]     live,
  input  logic [AGE_W-1:0] stamp [N],
  input  logic [AGE_W-1:0] now,
  input  logic [AGE_W-1:0] limit,
  output logic             stale
);
  logic [N-1:0] old;

  for (genvar k = 0; k < N; k++) begin : g_ent
    logic [AGE_W-1:0] age;
    assign age    = AGE_W'(now - stamp[k]);
    assign old[k] = live[k] && (age >= limit);
  end

  assign stale = |old;
endmodule

// File: rtl/line_coalesce_table.sv
module line_coalesce_table
  import coal_pkg::*;
#(
  parameter int LINE_W = 26,
  parameter int TAG_W  = 8,
  parameter int SLOTS  = 8,
  parameter int DEPTH  = 4,   // power of two
  parameter int AGE_W  = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              req_valid,
  output logic                              req_ready,
  input  logic [LINE_W-1:0]                 req_line,
  input  logic [2:0]                        req_kind,
  input  logic [2:0]                        req_fwd_kind,
  input  logic [TAG_W-1:0]                  req_tag,
  output logic                              req_alias,
  output logic                              req_retry,
  output logic                              iss_valid,
  input  logic                              iss_ready,
  output logic [LINE_W-1:0]                 iss_line,
  output logic [2:0]                        iss_kind,
  input  logic                              rsp_valid,
  output logic                              rsp_ready,
  input  logic [LINE_W-1:0]                 rsp_line,
  input  logic                              rsp_write,
  output logic                              cmp_valid,
  input  logic                              cmp_ready,
  output logic [TAG_W-1:0]                  cmp_tag,
  output logic                              cmp_ok,
  output logic [$clog2(SLOTS*DEPTH+1)-1:0]  out_count,
  input  logic [AGE_W-1:0]                  dl_limit,
  output logic                              dl_err
);
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int NENT   = SLOTS * DEPTH;
  localparam int OCNT_W = $clog2(NENT + 1);

  // slot state
  logic [SLOTS-1:0]  s_vld;
  logic [SLOTS-1:0]  s_lock;
  logic [LINE_W-1:0] s_line [SLOTS];
  logic [CNT_W-1:0]  s_cnt  [SLOTS];
  logic [PTR_W-1:0]  s_head [SLOTS];

  // entry storage
  logic [TAG_W-1:0]  e_tag   [SLOTS][DEPTH];
  logic [2:0]        e_kind  [SLOTS][DEPTH];
  logic [2:0]        e_kind2 [SLOTS][DEPTH];
  logic [AGE_W-1:0]  e_time  [SLOTS][DEPTH];

  // drain state
  logic              drn_busy;
  logic              drn_wr;
  logic [SLOT_W-1:0] drn_slot;
  logic [AGE_W-1:0]  now;

  // request lookup
  logic              req_hit, free_ok, rsp_hit, rsp_free_unused;
  logic [SLOT_W-1:0] req_idx, free_idx, rsp_idx, rsp_free_idx_unused;

  coal_lookup #(.SLOTS(SLOTS), .LINE_W(LINE_W), .SLOT_W(SLOT_W)) u_req_lk (
    .vld(s_vld), .lines(s_line), .key(req_line),
    .hit(req_hit), .hit_idx(req_idx), .has_free(free_ok), .free_idx(free_idx)
  );

  coal_lookup #(.SLOTS(SLOTS), .LINE_W(LINE_W), .SLOT_W(SLOT_W)) u_rsp_lk (
    .vld(s_vld), .lines(s_line), .key(rsp_line),
    .hit(rsp_hit), .hit_idx(rsp_idx), .has_free(rsp_free_unused),
    .free_idx(rsp_free_idx_unused)
  );

  // drain head view
  logic [CNT_W-1:0] d_cnt;
  logic [PTR_W-1:0] d_head;
  logic [2:0]       he_kind, he_kind2;
  logic [TAG_W-1:0] he_tag;
  logic             d_stop, d_reiss, d_pop, d_empty, lock_nx;
  logic             iss_free, cmp_free, iss_go_req;

  assign d_cnt    = s_cnt[drn_slot];
  assign d_head   = s_head[drn_slot];
  assign he_kind  = e_kind[drn_slot][d_head];
  assign he_kind2 = e_kind2[drn_slot][d_head];
  assign he_tag   = e_tag[drn_slot][d_head];
  assign iss_free = !iss_valid || iss_ready;
  assign cmp_free = !cmp_valid || cmp_ready;

  assign d_stop   = drn_busy && !drn_wr && (d_cnt != '0) && !k_is_read(he_kind);
  assign d_reiss  = d_stop && iss_free;
  assign d_pop    = drn_busy && (d_cnt != '0) && !d_stop && cmp_free;
  assign d_empty  = drn_busy && (d_cnt == '0);
  assign lock_nx  = (he_kind == K_LKRD) ? 1'b1 :
                    (he_kind == K_LKWR) ? 1'b0 : s_lock[drn_slot];
  assign iss_go_req = iss_free && !d_stop;

  // request decision
  logic [CNT_W-1:0] hcnt;
  logic             refuse, need_iss, drn_block, acc;
  logic [SLOT_W-1:0] ins_idx;
  logic [PTR_W-1:0]  wr_ptr;

  assign hcnt      = req_hit ? s_cnt[req_idx] : '0;
  assign drn_block = drn_busy && req_hit && (req_idx == drn_slot);
  assign refuse    = req_hit && s_lock[req_idx] && (req_kind != K_LKWR);
  assign need_iss  = !req_hit || (hcnt == '0);

  always_comb begin
    if (drn_block)     req_ready = 1'b0;
    else if (refuse)   req_ready = 1'b1;
    else if (req_hit)  req_ready = (hcnt < CNT_W'(DEPTH)) && (!need_iss || iss_go_req);
    else               req_ready = free_ok && iss_go_req;
  end

  assign req_retry = req_valid && refuse;
  assign req_alias = req_valid && req_hit && !refuse && (hcnt != '0);
  assign acc       = req_valid && req_ready && !refuse;
  assign ins_idx   = req_hit ? req_idx : free_idx;
  assign wr_ptr    = req_hit ? PTR_W'(s_head[req_idx] + PTR_W'(hcnt)) : '0;
  assign rsp_ready = !drn_busy;

  // slot bookkeeping
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_vld  <= '0;
      s_lock <= '0;
      for (int i = 0; i < SLOTS; i++) begin
        s_line[i] <= '0;
        s_cnt[i]  <= '0;
        s_head[i] <= '0;
      end
    end else begin
      for (int i = 0; i < SLOTS; i++) begin
        if (acc && (ins_idx == SLOT_W'(i))) begin
          if (!req_hit) begin
            s_vld[i]  <= 1'b1;
            s_line[i] <= req_line;
            s_lock[i] <= 1'b0;
            s_head[i] <= '0;
            s_cnt[i]  <= CNT_W'(1);
          end else begin
            s_cnt[i]  <= s_cnt[i] + CNT_W'(1);
          end
        end else if (drn_busy && (drn_slot == SLOT_W'(i))) begin
          if (d_pop) begin
            s_cnt[i]  <= s_cnt[i] - CNT_W'(1);
            s_head[i] <= s_head[i] + PTR_W'(1);
            s_lock[i] <= lock_nx;
            if ((d_cnt == CNT_W'(1)) && !lock_nx) s_vld[i] <= 1'b0;
          end else if (d_empty && !s_lock[i]) begin
            s_vld[i] <= 1'b0;
          end
        end
      end
    end
  end

  // entry write
  always_ff @(posedge clk) begin
    if (acc) begin
      e_tag[ins_idx][wr_ptr]   <= req_tag;
      e_kind[ins_idx][wr_ptr]  <= req_kind;
      e_kind2[ins_idx][wr_ptr] <= req_fwd_kind;
      e_time[ins_idx][wr_ptr]  <= now;
    end
  end

  // drain control
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drn_busy <= 1'b0;
      drn_wr   <= 1'b0;
      drn_slot <= '0;
    end else if (!drn_busy) begin
      if (rsp_valid && rsp_hit) begin
        drn_busy <= 1'b1;
        drn_wr   <= rsp_write;
        drn_slot <= rsp_idx;
      end
    end else if (d_reiss || d_empty || (d_pop && (d_cnt == CNT_W'(1)))) begin
      drn_busy <= 1'b0;
    end
  end

  // issue register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iss_valid <= 1'b0;
      iss_line  <= '0;
      iss_kind  <= '0;
    end else if (d_reiss) begin
      iss_valid <= 1'b1;
      iss_line  <= s_line[drn_slot];
      iss_kind  <= he_kind2;
    end else if (acc && need_iss) begin
      iss_valid <= 1'b1;
      iss_line  <= req_line;
      iss_kind  <= req_fwd_kind;
    end else if (iss_ready) begin
      iss_valid <= 1'b0;
    end
  end

  // completion register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_valid <= 1'b0;
      cmp_tag   <= '0;
      cmp_ok    <= 1'b0;
    end else if (d_pop) begin
      cmp_valid <= 1'b1;
      cmp_tag   <= he_tag;
      cmp_ok    <= !((he_kind == K_LKWR) && !s_lock[drn_slot]);
    end else if (cmp_ready) begin
      cmp_valid <= 1'b0;
    end
  end

  // global count and cycle stamp
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_count <= '0;
      now       <= '0;
    end else begin
      now <= now + AGE_W'(1);
      case ({acc, d_pop})
        2'b10:   out_count <= out_count + OCNT_W'(1);
        2'b01:   out_count <= out_count - OCNT_W'(1);
        default: out_count <= out_count;
      endcase
    end
  end

  // age supervision
  logic [NENT-1:0]  live_flat;
  logic [AGE_W-1:0] stamp_flat [NENT];
  logic             stale;

  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      for (int j = 0; j < DEPTH; j++) begin
        logic [PTR_W-1:0] off;
        off = PTR_W'(j) - s_head[i];
        live_flat[i*DEPTH+j]  = s_vld[i] && (CNT_W'(off) < s_cnt[i]);
        stamp_flat[i*DEPTH+j] = e_time[i][j];
      end
    end
  end

  coal_age_watch #(.N(NENT), .AGE_W(AGE_W)) u_age (
    .live(live_flat), .stamp(stamp_flat), .now(now), .limit(dl_limit), .stale(stale)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     dl_err <= 1'b0;
    else if (stale) dl_err <= 1'b1;
  end
endmodule

// File: rtl/coal_chk.sv
module coal_chk #(
  parameter int LINE_W = 26,
  parameter int TAG_W  = 8,
  parameter int OCNT_W = 6,
  parameter int CAP    = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_alias,
  input logic              req_retry,
  input logic [LINE_W-1:0] req_line,
  input logic              iss_valid,
  input logic              iss_ready,
  input logic [LINE_W-1:0] iss_line,
  input logic              cmp_valid,
  input logic              cmp_ready,
  input logic [TAG_W-1:0]  cmp_tag,
  input logic              cmp_ok,
  input logic [OCNT_W-1:0] out_count
);
  assert_first_issued_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_retry && !req_alias) |=>
      (iss_valid && (iss_line == $past(req_line))));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(out_count) <= CAP));

  assert_refused_not_counted_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_retry) |=> (out_count <= $past(out_count)));

  assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_count == $past(out_count)) ||
    (out_count == $past(out_count) + OCNT_W'(1)) ||
    (out_count + OCNT_W'(1) == $past(out_count)));

  assert_issue_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_ready) |=> (iss_valid && $stable(iss_line)));

  assert_cmp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && !cmp_ready) |=> (cmp_valid && $stable(cmp_tag) && $stable(cmp_ok)));
endmodule

bind line_coalesce_table coal_chk #(
  .LINE_W(LINE_W), .TAG_W(TAG_W),
  .OCNT_W($clog2(SLOTS*DEPTH+1)), .CAP(SLOTS*DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .req_valid(req_valid), .req_ready(req_ready), .req_alias(req_alias),
  .req_retry(req_retry), .req_line(req_line),
  .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_line(iss_line),
  .cmp_valid(cmp_valid), .cmp_ready(cmp_ready), .cmp_tag(cmp_tag), .cmp_ok(cmp_ok),
  .out_count(out_count)
);

// File: tb/sim_line_coalesce_table.sv
`timescale 1ns/1ps
module sim_line_coalesce_table;
  localparam int LINE_W = 26;
  localparam int TAG_W  = 8;
  localparam int SLOTS  = 8;
  localparam int DEPTH  = 4;
  localparam int AGE_W  = 16;
  localparam int OCW    = $clog2(SLOTS*DEPTH+1);

  localparam logic [3:0] OP_REQ = 4'd1, OP_RSP = 4'd2, OP_ISS = 4'd3,
                         OP_CMP = 4'd4, OP_CNT = 4'd5;
  // {op, line, kind, fwd kind, tag, e1, e2}
  localparam int NV = 44;
  localparam logic [43:0] TBL [NV] = '{
    {OP_REQ, 8'd10, 4'd0, 4'd0, 8'd1,  8'd0, 8'd0},
    {OP_ISS, 8'd10, 4'd0, 4'd0, 8'd0,  8'd0, 8'd0},
    {OP_REQ, 8'd10, 4'd0, 4'd0, 8'd2,  8'd1, 8'd0},
    {OP_REQ, 8'd10, 4'd2, 4'd2, 8'd3,  8'd1, 8'd0},
    {OP_REQ, 8'd10, 4'd0, 4'd0, 8'd4,  8'd1, 8'd0},
    {OP_CNT, 8'd0,  4'd0, 4'd0, 8'd0,  8'd4, 8'd0},
    {OP_RSP, 8'd10, 4'd0, 4'd0, 8'd0,  8'd0, 8'd0},
    {OP_CMP, 8'd0,  4'd0, 4'd0, 8'd0,  8'd1, 8'd1},
    {OP_CMP, 8'd0,  4'd0, 4'd0, 8'd0,  8'd2, 8'd1},
    {OP_ISS, 8'd10, 4'd2, 4'd0, 8'd0,  8'd0, 8'd0},
    {OP_CNT, 8'd0,  4'd0, 4'd0, 8'd0,  8'd2, 8'd0},
    {OP_RSP, 8'd10, 4'd1, 4'd0, 8'd0,  8'd0, 8'd0},
    {OP_CMP, 8'd0,  4'd0, 4'd0, 8'd0,  8'd3, 8'd1},
    {OP_CMP, 8'd0,  4'd0, 4'd0, 8'd0,  8'd4, 8'd1},
    {OP_CNT, 8'd0,  4'd0, 4'd0, 8'd0,  8'd0, 8'd0},
    {OP_REQ, 8'd20, 4'd1, 4'd1, 8'd5,  8'd0, 8'd0},
    {OP_ISS, 8'd20, 4'd1, 4'd0, 8'd0,  8'd0, 8'd0},
    {OP_REQ, 8'd21, 4'd2, 4'd2, 8'd6,  8'd0, 8'd0},
    {OP_ISS, 8'd21, 4'd2, 4'd0, 8'd0,  8'd0, 8'd0},
    {OP_REQ, 8'd21, 4'd0, 4'd0, 8'd7,  8'd1, 8'd0},
    {OP_RSP, 8'd21, 4'd1, 4'd0, 8'd0,  8'd0, 8'd0},
    {OP_CMP, 8'd0,  4'd0, 4'd0, 8'd0,  8'd6, 8'd1},
    {OP_CMP, 8'd0,  4'd0, 4'd0, 8'd0,  8'd7, 8'd1},
    {OP_RSP, 8'd20, 4'd0, 4'd0, 8'd0,  8'd0, 8'd0},
    {OP_CMP, 8'd0,  4'd0, 4'd0, 8'd0,  8'd5, 8'd1},
    {OP_REQ, 8'd30, 4'd3, 4'd3, 8'd8,  8'd0, 8'd0},
    {OP_ISS, 8'd30, 4'd3, 4'd0, 8'd0,  8'd0, 8'd0},
    {OP_RSP, 8'd30, 4'd1, 4'd0, 8'd0,  8'd0, 8'd0},
    {OP_CMP, 8'd0,  4'd0, 4'd0, 8'd0,  8'd8, 8'd1},
    {OP_REQ, 8'd30, 4'd0, 4'd0, 8'd9,  8'd2, 8'd0},
    {OP_CNT, 8'd0,  4'd0, 4'd0, 8'd0,  8'd0, 8'd0},
    {OP_REQ, 8'd30, 4'd4, 4'd4, 8'd10, 8'd0, 8'd0},
    {OP_ISS, 8'd30, 4'd4, 4'd0, 8'd0,  8'd0, 8'd0},
    {OP_RSP, 8'd30, 4'd1, 4'd0, 8'd0,  8'd0, 8'd0},
    {OP_CMP, 8'd0,  4'd0, 4'd0, 8'd0,  8'd10, 8'd1},
    {OP_REQ, 8'd30, 4'd0, 4'd0, 8'd11, 8'd0, 8'd0},
    {OP_ISS, 8'd30, 4'd0, 4'd0, 8'd0,  8'd0, 8'd0},
    {OP_RSP, 8'd30, 4'd0, 4'd0, 8'd0,  8'd0, 8'd0},
    {OP_CMP, 8'd0,  4'd0, 4'd0, 8'd0,  8'd11, 8'd1},
    {OP_REQ, 8'd40, 4'd4, 4'd4, 8'd12, 8'd0, 8'd0},
    {OP_ISS, 8'd40, 4'd4, 4'd0, 8'd0,  8'd0, 8'd0},
    {OP_RSP, 8'd40, 4'd1, 4'd0, 8'd0,  8'd0, 8'd0},
    {OP_CMP, 8'd0,  4'd0, 4'd0, 8'd0,  8'd12, 8'd0},
    {OP_CNT, 8'd0,  4'd0, 4'd0, 8'd0,  8'd0, 8'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, req_alias, req_retry;
  logic [LINE_W-1:0] req_line = '0;
  logic [2:0] req_kind = '0, req_fwd_kind = '0;
  logic [TAG_W-1:0] req_tag = '0;
  logic iss_valid, iss_ready = 1'b1;
  logic [LINE_W-1:0] iss_line;
  logic [2:0] iss_kind;
  logic rsp_valid = 1'b0, rsp_ready, rsp_write = 1'b0;
  logic [LINE_W-1:0] rsp_line = '0;
  logic cmp_valid, cmp_ready = 1'b1, cmp_ok;
  logic [TAG_W-1:0] cmp_tag;
  logic [OCW-1:0] out_count;
  logic [AGE_W-1:0] dl_limit = AGE_W'(1000);
  logic dl_err;

  always #10 clk = ~clk;

  line_coalesce_table #(.LINE_W(LINE_W), .TAG_W(TAG_W), .SLOTS(SLOTS),
                        .DEPTH(DEPTH), .AGE_W(AGE_W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_line(req_line),
    .req_kind(req_kind), .req_fwd_kind(req_fwd_kind), .req_tag(req_tag),
    .req_alias(req_alias), .req_retry(req_retry),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_line(iss_line), .iss_kind(iss_kind),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_line(rsp_line), .rsp_write(rsp_write),
    .cmp_valid(cmp_valid), .cmp_ready(cmp_ready), .cmp_tag(cmp_tag), .cmp_ok(cmp_ok),
    .out_count(out_count), .dl_limit(dl_limit), .dl_err(dl_err)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // transfer logs
  int iss_lg_line [256];
  int iss_lg_kind [256];
  int cmp_lg_tag  [256];
  int cmp_lg_ok   [256];
  int iss_wr = 0, iss_rd = 0, cmp_wr = 0, cmp_rd = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (iss_valid && iss_ready && iss_wr < 256) begin
        iss_lg_line[iss_wr] = int'(iss_line);
        iss_lg_kind[iss_wr] = int'(iss_kind);
        iss_wr++;
      end
      if (cmp_valid && cmp_ready && cmp_wr < 256) begin
        cmp_lg_tag[cmp_wr] = int'(cmp_tag);
        cmp_lg_ok[cmp_wr]  = int'(cmp_ok);
        cmp_wr++;
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic do_reset();
    req_valid = 1'b0; rsp_valid = 1'b0;
    iss_ready = 1'b1; cmp_ready = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    iss_rd = iss_wr; cmp_rd = cmp_wr;
  endtask

  task automatic do_req(input int line, input int kind, input int kind2,
                        input int tag, input int exp);
    int got;
    @(posedge clk); #1;
    req_valid = 1'b1; req_line = LINE_W'(line);
    req_kind = 3'(kind); req_fwd_kind = 3'(kind2); req_tag = TAG_W'(tag);
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    got = req_retry ? 2 : (req_alias ? 1 : 0);
    if (exp == 0)      chk(got == exp, "R1 first request issued", got, exp);
    else if (exp == 1) chk(got == exp, "R2 same-line request aliased", got, exp);
    else               chk(got == exp, "R6 locked line refuses", got, exp);
    @(posedge clk); #1;
    req_valid = 1'b0;
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic do_rsp(input int line, input bit wr);
    @(posedge clk); #1;
    rsp_valid = 1'b1; rsp_line = LINE_W'(line); rsp_write = wr;
    forever begin
      @(negedge clk);
      if (rsp_ready) break;
    end
    @(posedge clk); #1;
    rsp_valid = 1'b0;
    repeat (DEPTH + 4) @(posedge clk);
    #1;
  endtask

  task automatic chk_iss(input int line, input int kind, input string rq);
    if (iss_rd >= iss_wr) begin
      chk(1'b0, rq, -1, line);
    end else begin
      chk(iss_lg_line[iss_rd] == line, rq, iss_lg_line[iss_rd], line);
      chk(iss_lg_kind[iss_rd] == kind, rq, iss_lg_kind[iss_rd], kind);
      iss_rd++;
    end
  endtask

  task automatic chk_cmp(input int tag, input int ok, input string rq);
    if (cmp_rd >= cmp_wr) begin
      chk(1'b0, rq, -1, tag);
    end else begin
      chk(cmp_lg_tag[cmp_rd] == tag, rq, cmp_lg_tag[cmp_rd], tag);
      chk(cmp_lg_ok[cmp_rd] == ok, "R7 completion ok bit", cmp_lg_ok[cmp_rd], ok);
      cmp_rd++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R10 reset state
    @(negedge clk);
    chk(req_ready == 1'b1, "R10 ready after reset", int'(req_ready), 1);
    chk(iss_valid == 1'b0, "R10 no issue after reset", int'(iss_valid), 0);
    chk(cmp_valid == 1'b0, "R10 no completion after reset", int'(cmp_valid), 0);
    chk(out_count == '0, "R10 count after reset", int'(out_count), 0);
    chk(dl_err == 1'b0, "R10 error clear after reset", int'(dl_err), 0);

    // stimulus table (R1 R2 R4 R5 R6 R7 R8)
    for (int v = 0; v < NV; v++) begin
      logic [43:0] t;
      t = TBL[v];
      case (t[43:40])
        OP_REQ: do_req(int'(t[39:32]), int'(t[31:28]), int'(t[27:24]),
                       int'(t[23:16]), int'(t[15:8]));
        OP_RSP: do_rsp(int'(t[39:32]), t[28]);
        OP_ISS: chk_iss(int'(t[39:32]), int'(t[31:28]), "R5 issue order/kind");
        OP_CMP: chk_cmp(int'(t[15:8]), int'(t[7:0]), "R4 completion order");
        OP_CNT: begin
          @(negedge clk);
          chk(int'(out_count) == int'(t[15:8]), "R8 outstanding count",
              int'(out_count), int'(t[15:8]));
        end
        default: ;
      endcase
    end
    chk(iss_rd == iss_wr, "R6 no extra issue", iss_wr, iss_rd);

    // R3 line queue full
    do_reset();
    for (int k = 0; k < DEPTH; k++) do_req(50, 0, 0, 60 + k, (k == 0) ? 0 : 1);
    @(posedge clk); #1;
    req_valid = 1'b1; req_line = LINE_W'(50); req_kind = 3'd0; req_tag = 8'd99;
    @(negedge clk);
    chk(req_ready == 1'b0, "R3 full line queue", int'(req_ready), 0);
    @(posedge clk); #1 req_valid = 1'b0;
    do_rsp(50, 1'b1);
    for (int k = 0; k < DEPTH; k++) chk_cmp(60 + k, 1, "R4 full queue drain order");
    chk(out_count == '0, "R8 count after drain", int'(out_count), 0);

    // R12 slot exhaustion and release
    do_reset();
    for (int k = 0; k < SLOTS; k++) do_req(100 + k, 0, 0, 110 + k, 0);
    @(posedge clk); #1;
    req_valid = 1'b1; req_line = LINE_W'(100 + SLOTS); req_kind = 3'd0;
    @(negedge clk);
    chk(req_ready == 1'b0, "R3 no free slot", int'(req_ready), 0);
    @(posedge clk); #1 req_valid = 1'b0;
    do_req(100, 0, 0, 120, 1);
    do_rsp(100, 1'b1);
    chk_cmp(110, 1, "R4 slot drain");
    chk_cmp(120, 1, "R4 slot drain");
    do_req(100 + SLOTS, 0, 0, 121, 0);
    @(negedge clk);
    chk(int'(out_count) == SLOTS, "R12 slot reused", int'(out_count), SLOTS);

    // R11 back-pressure on issue and completion
    do_reset();
    iss_ready = 1'b0;
    do_req(70, 2, 2, 80, 0);
    @(negedge clk);
    chk(iss_valid && iss_line == LINE_W'(70), "R11 issue held", int'(iss_line), 70);
    @(posedge clk); #1;
    req_valid = 1'b1; req_line = LINE_W'(71); req_kind = 3'd0;
    @(negedge clk);
    chk(req_ready == 1'b0, "R3 issue port busy", int'(req_ready), 0);
    chk(iss_valid && iss_line == LINE_W'(70), "R11 issue still held", int'(iss_line), 70);
    @(posedge clk); #1 req_valid = 1'b0;
    do_req(70, 0, 0, 81, 1);
    iss_ready = 1'b1;
    repeat (2) @(posedge clk);
    chk_iss(70, 2, "R11 issue after release");
    cmp_ready = 1'b0;
    do_rsp(70, 1'b1);
    @(negedge clk);
    chk(cmp_valid && cmp_tag == TAG_W'(80), "R11 completion held", int'(cmp_tag), 80);
    chk(int'(out_count) == 1, "R8 count under stall", int'(out_count), 1);
    cmp_ready = 1'b1;
    repeat (4) @(posedge clk);
    chk_cmp(80, 1, "R11 completion order");
    chk_cmp(81, 1, "R11 completion order");

    // R9 stall error
    do_reset();
    dl_limit = AGE_W'(50);
    do_req(90, 0, 0, 91, 0);
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk(dl_err == 1'b0, "R9 error not yet", int'(dl_err), 0);
    repeat (40) @(posedge clk);
    @(negedge clk);
    chk(dl_err == 1'b1, "R9 error raised", int'(dl_err), 1);
    do_rsp(90, 1'b0);
    @(negedge clk);
    chk(dl_err == 1'b1, "R9 error sticky", int'(dl_err), 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule